// File: doc/BRIEF.md
# Glitch-Free Programmable Output Clock Divider

This block produces one clock output from one of four incoming clocks: a reference clock and three synthesized clocks. A static configuration field picks the source. The selected clock is divided by an integer. That integer comes from one of four stored presets, and a 2-bit frequency-select value chooses which preset is active. A new divide value is only adopted at the end of a full output period, when the output is low. As a result, a frequency change never produces a shortened high or low phase.

The high bit of the frequency select shares a multifunction pin with two other duties, so a configuration field decides the pin's role. The pin can act as the upper select bit. It can act as an active-low power-down that holds the block in its reset state and restarts it from the configured presets when released. It can also act as an output enable, which gates the output only when the per-output sensitivity bit is set. Both select inputs are synchronized into the selected clock domain before use. The source selection is expected to change only while reset is asserted.

Top module: `clkdiv_out`

## Requirements
- R1: `cfg_src_i` = k routes `src_clk_i[k]` to the divider, for each of the four values of k.
- R2: For an effective divide value N of 2 or more, the output period is N source cycles: high for (N+1)/2 cycles (rounded down) and low for the rest.
- R3: An effective divide value of 1 passes the selected clock through unchanged. A stored preset of 0 behaves as 1.
- R4: The active preset index is {hi, `fs0_i`}, with preset k held at bits [k*DIVW +: DIVW] of `cfg_div_i`. Here hi is the multifunction pin when `cfg_mf_mode_i` = 2'b00 and 0 for every other mode.
- R5: A change of preset takes effect only at an output period boundary. Every high or low phase has the full length of either the old or the new setting.
- R6: With `cfg_mf_mode_i` = 2'b10 and `cfg_oe_sens_i` = 1, a low pin holds the output low from the next period boundary, and a high pin lets it run. With `cfg_oe_sens_i` = 0, the pin has no effect.
- R7: With `cfg_mf_mode_i` = 2'b01, a low pin forces the output low. After the pin rises, the block restarts with the preset chosen by {0, `fs0_i`}.
- R8: While `rst_n_i` is low, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 4 | Candidate clocks; bit 0 is the reference |
| rst_n_i | input | 1 | Synchronous active-low reset, in the selected clock domain |
| cfg_src_i | input | 2 | Source clock index |
| cfg_div_i | input | 4*DIVW | Four packed divide presets |
| cfg_mf_mode_i | input | 2 | Multifunction pin role: 00 select bit, 01 power-down, 10 enable, 11 unused |
| cfg_oe_sens_i | input | 1 | Output responds to the enable role when set |
| fs0_i | input | 1 | Low frequency-select bit |
| mf_pin_i | input | 1 | Multifunction pin |
| clk_o | output | 1 | Divided clock output |

## Verification
A change on `fs0_i` or the multifunction pin needs two flops to reach the logic. After that, a preset or enable change waits for the next period boundary, so it lands within 2 + 2N source cycles (N being the larger divide value involved). Power-down adds only the synchronizer and one register, so it lands within four cycles. The bench waits past these bounds before it measures high and low run lengths. It samples the output 2 ns after each reference rising edge, where both the pass-through high phase and the registered divider output have settled. During glitch sweeps, the select is toggled at every phase offset, and each completed run is compared against the run lengths that the old and new divide values allow.

// File: rtl/clkdiv_pkg.sv
// Shared types for the output clock divider.
// Assumes: the multifunction pin role encoding is fixed by configuration.
package clkdiv_pkg;
    typedef enum logic [1:0] {
        MF_FSEL  = 2'b00,
        MF_PDOWN = 2'b01,
        MF_OEN   = 2'b10,
        MF_NONE  = 2'b11
    } mf_mode_e;
endpackage

// File: rtl/clkdiv_sync.sv
// Two-flop synchronizer for a bus of independent single-bit controls.
// Assumes: each bit is treated on its own, so no multi-bit coherence is needed.
module clkdiv_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Capture the asynchronous inputs and resample them once.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/clkdiv_core.sv
// Integer divider with boundary-only reload and enable gating.
// Assumes: div_sel_i and en_i are already synchronous to clk_i; 0 means 1.
module clkdiv_core #(
    parameter int DIVW = 4
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic [DIVW-1:0] div_sel_i,
    input  logic            en_i,
    output logic            active_o,
    output logic            clk_o
);
    logic [DIVW-1:0] n_q;
    logic [DIVW-1:0] cnt_q;
    logic            out_q;
    logic            on_q;
    logic            gate_q;
    logic [DIVW-1:0] n_new;
    logic [DIVW-1:0] cnt_nxt;
    logic            wrap;
    logic            pass;

    // High-phase length, rounded up, with no overflow at the top value.
    function automatic logic [DIVW-1:0] half_up(input logic [DIVW-1:0] n);
        return (n >> 1) + {{(DIVW-1){1'b0}}, n[0]};
    endfunction

    // Clamp a zero preset to one and find the period boundary.
    always_comb begin
        n_new   = (div_sel_i == '0) ? {{(DIVW-1){1'b0}}, 1'b1} : div_sel_i;
        wrap    = (cnt_q == n_q - 1'b1);
        cnt_nxt = cnt_q + 1'b1;
        pass    = (n_q == {{(DIVW-1){1'b0}}, 1'b1});
    end

    // Count source cycles and adopt new settings only at the boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            n_q   <= {{(DIVW-1){1'b0}}, 1'b1};
            cnt_q <= '0;
            out_q <= 1'b0;
            on_q  <= 1'b0;
        end else if (wrap) begin
            n_q   <= n_new;
            cnt_q <= '0;
            on_q  <= en_i;
            out_q <= en_i && (n_new > {{(DIVW-1){1'b0}}, 1'b1});
        end else begin
            cnt_q <= cnt_nxt;
            out_q <= on_q && (cnt_nxt < half_up(n_q));
        end
    end

    // Update the pass-through gate while the clock is low.
    always_ff @(negedge clk_i) begin
        if (!rst_n_i) gate_q <= 1'b0;
        else          gate_q <= on_q && pass;
    end

    assign clk_o    = pass ? (clk_i & gate_q) : out_q;
    assign active_o = on_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cnt_q < n_q); // R2
    AST_HIGH_FIRST_HALF: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        out_q |-> (cnt_q < half_up(n_q))); // R2
    AST_RELOAD_WHEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (n_q != $past(n_q)) |-> !$past(out_q)); // R5
    AST_OFF_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !on_q |-> !out_q); // R6
endmodule

// File: rtl/clkdiv_out.sv
// Top: source selection, multifunction pin decode, preset pick, divider.
// Assumes: cfg_src_i changes only while rst_n_i is low.
module clkdiv_out #(
    parameter int DIVW = 4
) (
    input  logic [3:0]        src_clk_i,
    input  logic              rst_n_i,
    input  logic [1:0]        cfg_src_i,
    input  logic [4*DIVW-1:0] cfg_div_i,
    input  logic [1:0]        cfg_mf_mode_i,
    input  logic              cfg_oe_sens_i,
    input  logic              fs0_i,
    input  logic              mf_pin_i,
    output logic              clk_o
);
    import clkdiv_pkg::*;

    localparam int NPRE = 4;
    localparam int IDXW = $clog2(NPRE);

    logic            sel_clk;
    logic [1:0]      sync_q;
    logic            fs0_s;
    logic            mf_s;
    mf_mode_e        mode;
    logic            pd_act;
    logic            core_rst_n;
    logic            en;
    logic [IDXW-1:0] idx;
    logic [DIVW-1:0] div_sel;
    logic            core_active;

    assign sel_clk = src_clk_i[cfg_src_i];

    clkdiv_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk_i   (sel_clk),
        .rst_n_i (rst_n_i),
        .d_i     ({mf_pin_i, fs0_i}),
        .q_o     (sync_q)
    );

    // Decode the pin role and pick the active preset.
    always_comb begin
        fs0_s      = sync_q[0];
        mf_s       = sync_q[1];
        mode       = mf_mode_e'(cfg_mf_mode_i);
        pd_act     = (mode == MF_PDOWN) && !mf_s;
        core_rst_n = rst_n_i && !pd_act;
        en         = !((mode == MF_OEN) && cfg_oe_sens_i) || mf_s;
        idx        = {(mode == MF_FSEL) && mf_s, fs0_s};
        div_sel    = cfg_div_i[idx*DIVW +: DIVW];
    end

    clkdiv_core #(.DIVW(DIVW)) u_core (
        .clk_i     (sel_clk),
        .rst_n_i   (core_rst_n),
        .div_sel_i (div_sel),
        .en_i      (en),
        .active_o  (core_active),
        .clk_o     (clk_o)
    );

    AST_PD_STOPS: assert property (@(posedge sel_clk) disable iff (!rst_n_i)
        pd_act |=> !core_active); // R7
endmodule

// File: tb/clkdiv_out_tb.sv
module clkdiv_out_tb;
    localparam int DIVW = 4;

    logic clk = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_src = 2'd0;
    logic [4*DIVW-1:0] cfg_div = '0;
    logic [1:0] cfg_mode = 2'b00;
    logic cfg_sens = 1'b0;
    logic fs0 = 1'b0;
    logic mf_pin = 1'b0;
    logic clk_o;
    int errs = 0, checks = 0, ecount = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always #5 c1 = ~c1;
    always #6 c2 = ~c2;
    always #10 c3 = ~c3;

    clkdiv_out #(.DIVW(DIVW)) u_dut (
        .src_clk_i ({c3, c2, c1, clk}), .rst_n_i (rst_n), .cfg_src_i (cfg_src),
        .cfg_div_i (cfg_div), .cfg_mf_mode_i (cfg_mode), .cfg_oe_sens_i (cfg_sens),
        .fs0_i (fs0), .mf_pin_i (mf_pin), .clk_o (clk_o)
    );

    always @(posedge clk_o) ecount++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic smp(output bit v);
        @(posedge clk); #2; v = clk_o;
    endtask

    task automatic wait_cyc(input int n);
        bit v;
        for (int i = 0; i < n; i++) smp(v);
    endtask

    task automatic measure(output int h, output int l);
        bit v; int g;
        h = 0; l = 0; g = 0;
        do begin smp(v); g++; end while (v && g < 200);
        do begin smp(v); g++; end while (!v && g < 200);
        h = 1;
        do begin smp(v); g++; if (v) h++; end while (v && g < 200);
        l = 1;
        do begin smp(v); g++; if (!v) l++; end while (!v && g < 200);
    endtask

    task automatic set_presets(input int p0, input int p1, input int p2, input int p3);
        cfg_div = {4'(p3), 4'(p2), 4'(p1), 4'(p0)};
    endtask

    task automatic check_div(input int n, input string req);
        int h, l;
        measure(h, l);
        chk(h == (n + 1) / 2, req, h, (n + 1) / 2);
        chk(l == n / 2, req, l, n / 2);
    endtask

    task automatic check_pass(input string req);
        bit hi_ok = 1, lo_ok = 1;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2; if (clk_o !== 1'b1) hi_ok = 0;
            #4; if (clk_o !== 1'b0) lo_ok = 0;
        end
        chk(hi_ok, req, hi_ok, 1);
        chk(lo_ok, req, lo_ok, 1);
    endtask

    task automatic check_low(input int n, input string req);
        bit v; int highs = 0;
        for (int i = 0; i < n; i++) begin smp(v); if (v) highs++; end
        chk(highs == 0, req, highs, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #300;
        @(posedge clk); #2; rst_n = 1'b1;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int h, l;
        bit v;
        set_presets(2, 3, 4, 5);
        // R8: output held low under reset
        #20;
        check_low(10, "R8");
        do_reset();
        wait_cyc(10);

        // R2, R4: every select combination with the pin as high select bit
        for (int k = 0; k < 4; k++) begin
            fs0 = k[0]; mf_pin = k[1];
            wait_cyc(16);
            check_div(k + 2, "R4");
        end
        // R2: sweep of divide values 2..15
        mf_pin = 0; fs0 = 0;
        for (int n = 2; n < 16; n++) begin
            set_presets(n, 3, 4, 5);
            wait_cyc(40);
            check_div(n, "R2");
        end
        // R3: divide by one and zero preset act as pass-through
        set_presets(1, 0, 4, 5);
        wait_cyc(20);
        check_pass("R3");
        fs0 = 1;
        wait_cyc(20);
        check_pass("R3");

        // R4: reserved mode ignores the pin for the high bit
        set_presets(2, 3, 4, 5);
        cfg_mode = 2'b11; mf_pin = 1; fs0 = 1;
        wait_cyc(20);
        check_div(3, "R4");

        // R5: preset change at every phase offset, runs must be full length
        set_presets(3, 6, 4, 5);
        cfg_mode = 2'b00; mf_pin = 0;
        for (int off = 0; off < 8; off++) begin
            bit prev, started; int run;
            fs0 = 0;
            wait_cyc(30 + off);
            smp(prev); run = 1; started = 0;
            for (int i = 0; i < 80; i++) begin
                if (i == 12) fs0 = 1;
                if (i == 45) fs0 = 0;
                smp(v);
                if (v == prev) run++;
                else begin
                    if (started) begin
                        if (prev) chk(run == 2 || run == 3, "R5 high run", run, 2);
                        else      chk(run == 1 || run == 3, "R5 low run", run, 1);
                    end
                    started = 1; run = 1; prev = v;
                end
            end
        end

        // R6: enable role with sensitivity
        set_presets(4, 3, 4, 5);
        fs0 = 0; cfg_mode = 2'b10; cfg_sens = 1; mf_pin = 1;
        wait_cyc(20);
        check_div(4, "R6 enabled");
        mf_pin = 0;
        wait_cyc(12);
        check_low(20, "R6 disabled");
        mf_pin = 1;
        wait_cyc(12);
        check_div(4, "R6 re-enabled");
        cfg_sens = 0; mf_pin = 0;
        wait_cyc(12);
        check_div(4, "R6 insensitive");

        // R7: power-down role
        cfg_mode = 2'b01; mf_pin = 0;
        wait_cyc(4);
        check_low(20, "R7 down");
        set_presets(5, 3, 4, 2);
        mf_pin = 1;
        wait_cyc(16);
        check_div(5, "R7 restart");

        // R1: each source, divide by two, edge count over 4000 ns
        cfg_mode = 2'b00; mf_pin = 0; fs0 = 0;
        set_presets(2, 2, 2, 2);
        for (int k = 0; k < 4; k++) begin
            int per, exp, got;
            per = (k == 0) ? 8 : (k == 1) ? 10 : (k == 2) ? 12 : 20;
            rst_n = 0;
            cfg_src = 2'(k);
            #400;
            rst_n = 1;
            #400;
            ecount = 0;
            #4000;
            got = ecount;
            exp = 4000 / (2 * per);
            chk(got >= exp - 2 && got <= exp + 2, "R1", got, exp);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule